// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out one atomic memory instruction of a 64-bit register-machine ISA at a time. The issuing pipeline presents the instruction opcode byte, the low byte of the immediate (which selects the operation), the base register value, a signed 16-bit displacement, the source register value and the current value of register r0, together with a one-cycle `start`. The sequencer reads the addressed word, computes the new value, writes it back when required and returns the register writebacks. It keeps a `lock` output raised for the whole memory exchange so that an outside arbiter can keep other masters away.

The sequence is built from seven named states. S_IDLE accepts `start`. S_RD_REQ raises a read request for one cycle. S_RD_WAIT waits for `mem_ready` and captures the old value. S_CALC forms the new value. S_WR_REQ raises a write request for one cycle. S_WR_WAIT waits for the write to be acknowledged. S_FINISH pulses `done` and the writeback strobes.

The transitions are as follows. S_IDLE goes to S_RD_REQ when `start` arrives with a legal instruction. S_RD_REQ goes to S_RD_WAIT on the next cycle. S_RD_WAIT goes to S_CALC when `mem_ready` is high. S_CALC goes to S_WR_REQ, except that a compare-exchange whose comparison fails goes straight to S_FINISH. S_WR_REQ goes to S_WR_WAIT on the next cycle. S_WR_WAIT goes to S_FINISH when `mem_ready` is high. S_FINISH returns to S_IDLE. An illegal instruction leaves the sequencer in S_IDLE and raises `error` for one cycle.

Top module: `atomic_rmw_unit`

## Requirements
- R1: The opcode byte is accepted only when bits 2:0 are 3'b011, bits 7:5 are 3'b110 and bits 4:3 are 2'b00 (32-bit access, byte 0xC3) or 2'b11 (64-bit access, byte 0xDB). `mem_wide` is 1 for the 64-bit size.
- R2: The immediate byte selects the operation in bits 7:4 and the flag in bits 3:0. Legal bytes are 0x00/0x01 add, 0x40/0x41 or, 0x50/0x51 and, 0xA0/0xA1 xor, 0xE1 exchange and 0xF1 compare-exchange. A flag value of 1 means fetch.
- R3: `mem_addr` equals `base_addr` plus `offset` sign-extended to the address width, and it stays stable for the whole transaction.
- R4: Each transaction issues a read request first. A write request, when one is issued, comes only after the read data has returned. `lock` is high from the read request through the end of the write, and `mem_req` is never high while `lock` is low.
- R5: Add, or, and and xor write to memory the old value combined with the source value by the selected operation.
- R6: Fetch variants and exchange pulse `src_we` in the `done` cycle with `src_wdata` equal to the old memory value. Non-fetch variants leave `src_we` low. `done` lasts exactly one cycle.
- R7: Exchange writes the source value to memory unchanged.
- R8: Compare-exchange writes the source value only when r0 equals the old value; otherwise it issues no write. In both cases it pulses `r0_we` with `r0_wdata` equal to the old value, and it never pulses `src_we`.
- R9: For the 32-bit size, only bits 31:0 of the read data, the source and r0 take part. Bits 63:32 of `mem_wdata` are zero, and register writebacks are zero-extended.
- R10: An illegal opcode or immediate byte raises `error` for exactly the cycle after `start`. It issues no memory request and pulses no writeback or `done`.
- R11: After reset, `busy`, `lock`, `mem_req`, `done`, `error` and both writeback strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| start | input | 1 | One-cycle request to begin an instruction |
| opcode | input | 8 | Instruction opcode byte |
| imm_op | input | 8 | Low byte of the immediate (operation and flag) |
| base_addr | input | ADDR_W | Base register value |
| offset | input | OFF_W | Signed displacement |
| src_val | input | DATA_W | Source register value |
| r0_val | input | DATA_W | Value of register r0 |
| busy | output | 1 | Sequencer is not idle |
| done | output | 1 | Instruction completed (one-cycle pulse) |
| error | output | 1 | Illegal instruction rejected (one-cycle pulse) |
| lock | output | 1 | Memory exchange in progress |
| mem_req | output | 1 | Memory request (one-cycle pulse) |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | Access is 64-bit (0 means 32-bit) |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory completion strobe |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| src_we | output | 1 | Write strobe for the source register |
| src_wdata | output | DATA_W | Value for the source register |
| r0_we | output | 1 | Write strobe for r0 |
| r0_wdata | output | DATA_W | Value for r0 |

## Verification
The bench builds the block with its default parameters: a 64-bit data path, a 32-bit address and a 16-bit displacement. The 32-bit address lets a negative displacement wrap below the base, and the 64-bit data path allows a 32-bit access to return data whose upper half is not zero, so the bench can show that the unused half is ignored. The memory model in the bench returns data with a latency of zero, one or three cycles. This checks that every wait state holds for as long as the memory needs, and that the failing compare-exchange path skips the write entirely.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

    typedef enum logic [2:0] {
        AK_ADD,
        AK_OR,
        AK_AND,
        AK_XOR,
        AK_XCHG,
        AK_CAS
    } amo_kind_e;

    typedef struct packed {
        logic      legal;
        logic      wide;
        logic      fetch;
        amo_kind_e kind;
    } amo_dec_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_REQ,
        S_RD_WAIT,
        S_CALC,
        S_WR_REQ,
        S_WR_WAIT,
        S_FINISH
    } seq_state_e;

    localparam logic [2:0] CLS_STORE_REG = 3'b011;
    localparam logic [2:0] MODE_ATOMIC   = 3'b110;
    localparam logic [1:0] SZ_WORD       = 2'b00;
    localparam logic [1:0] SZ_DWORD      = 2'b11;

    localparam logic [3:0] FLG_NONE  = 4'h0;
    localparam logic [3:0] FLG_FETCH = 4'h1;

    localparam logic [3:0] NIB_ADD  = 4'h0;
    localparam logic [3:0] NIB_OR   = 4'h4;
    localparam logic [3:0] NIB_AND  = 4'h5;
    localparam logic [3:0] NIB_XOR  = 4'hA;
    localparam logic [3:0] NIB_XCHG = 4'hE;
    localparam logic [3:0] NIB_CAS  = 4'hF;

endpackage

// File: rtl/atomic_rmw_decode.sv
module atomic_rmw_decode
    import atomic_rmw_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] imm_op,
    output amo_dec_t   dec
);
    logic       class_ok;
    logic       size_ok;
    logic       op_ok;
    logic [3:0] flag;

    always_comb begin
        flag     = imm_op[3:0];
        class_ok = (opcode[2:0] == CLS_STORE_REG) && (opcode[7:5] == MODE_ATOMIC);
        size_ok  = (opcode[4:3] == SZ_WORD) || (opcode[4:3] == SZ_DWORD);
        op_ok    = 1'b0;
        dec.kind = AK_ADD;
        unique case (imm_op[7:4])
            NIB_ADD: begin
                dec.kind = AK_ADD;
                op_ok    = (flag == FLG_NONE) || (flag == FLG_FETCH);
            end
            NIB_OR: begin
                dec.kind = AK_OR;
                op_ok    = (flag == FLG_NONE) || (flag == FLG_FETCH);
            end
            NIB_AND: begin
                dec.kind = AK_AND;
                op_ok    = (flag == FLG_NONE) || (flag == FLG_FETCH);
            end
            NIB_XOR: begin
                dec.kind = AK_XOR;
                op_ok    = (flag == FLG_NONE) || (flag == FLG_FETCH);
            end
            NIB_XCHG: begin
                dec.kind = AK_XCHG;
                op_ok    = (flag == FLG_FETCH);
            end
            NIB_CAS: begin
                dec.kind = AK_CAS;
                op_ok    = (flag == FLG_FETCH);
            end
            default: begin
                dec.kind = AK_ADD;
                op_ok    = 1'b0;
            end
        endcase
        dec.fetch = (flag == FLG_FETCH);
        dec.wide  = (opcode[4:3] == SZ_DWORD);
        dec.legal = class_ok && size_ok && op_ok;
    end

endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
    import atomic_rmw_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_kind_e           kind,
    input  logic                wide,
    input  logic [DATA_W-1:0]   old_val,
    input  logic [DATA_W-1:0]   src_val,
    input  logic [DATA_W-1:0]   r0_val,
    output logic [DATA_W-1:0]   new_val,
    output logic                need_write
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] b_m;
    logic [DATA_W-1:0] c_m;
    logic [DATA_W-1:0] raw;

    always_comb begin
        mask = wide ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
        a_m  = old_val & mask;
        b_m  = src_val & mask;
        c_m  = r0_val  & mask;
        unique case (kind)
            AK_ADD:  raw = a_m + b_m;
            AK_OR:   raw = a_m | b_m;
            AK_AND:  raw = a_m & b_m;
            AK_XOR:  raw = a_m ^ b_m;
            AK_XCHG: raw = b_m;
            AK_CAS:  raw = b_m;
            default: raw = a_m;
        endcase
        new_val    = raw & mask;
        need_write = (kind != AK_CAS) || (a_m == c_m);
    end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atomic_rmw_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [7:0]        imm_op,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] r0_val,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              lock,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              src_we,
    output logic [DATA_W-1:0] src_wdata,
    output logic              r0_we,
    output logic [DATA_W-1:0] r0_wdata
);
    localparam int HALF_W = DATA_W / 2;
    localparam int EXT_W  = ADDR_W - OFF_W;

    seq_state_e        state, nxt;
    amo_dec_t          dec_in, dec_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] src_q, r0_q, old_q, wdata_q;
    logic [DATA_W-1:0] alu_val;
    logic              alu_need;
    logic              err_q;

    atomic_rmw_decode u_dec (
        .opcode (opcode),
        .imm_op (imm_op),
        .dec    (dec_in)
    );

    atomic_rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .kind       (dec_q.kind),
        .wide       (dec_q.wide),
        .old_val    (old_q),
        .src_val    (src_q),
        .r0_val     (r0_q),
        .new_val    (alu_val),
        .need_write (alu_need)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start && dec_in.legal) nxt = S_RD_REQ;
            S_RD_REQ:  nxt = S_RD_WAIT;
            S_RD_WAIT: if (mem_ready) nxt = S_CALC;
            S_CALC:    nxt = alu_need ? S_WR_REQ : S_FINISH;
            S_WR_REQ:  nxt = S_WR_WAIT;
            S_WR_WAIT: if (mem_ready) nxt = S_FINISH;
            S_FINISH:  nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // operand and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q   <= '0;
            addr_q  <= '0;
            src_q   <= '0;
            r0_q    <= '0;
            old_q   <= '0;
            wdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= (state == S_IDLE) && start && !dec_in.legal;
            if (state == S_IDLE && start && dec_in.legal) begin
                dec_q  <= dec_in;
                addr_q <= base_addr + {{EXT_W{offset[OFF_W-1]}}, offset};
                src_q  <= src_val;
                r0_q   <= r0_val;
            end
            if (state == S_RD_WAIT && mem_ready)
                old_q <= dec_q.wide ? mem_rdata
                                    : {{(DATA_W-HALF_W){1'b0}}, mem_rdata[HALF_W-1:0]};
            if (state == S_CALC)
                wdata_q <= alu_val;
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        lock      = (state == S_RD_REQ) || (state == S_RD_WAIT) || (state == S_CALC) ||
                    (state == S_WR_REQ) || (state == S_WR_WAIT);
        mem_req   = (state == S_RD_REQ) || (state == S_WR_REQ);
        mem_we    = (state == S_WR_REQ);
        mem_wide  = dec_q.wide;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        done      = (state == S_FINISH);
        error     = err_q;
        src_we    = (state == S_FINISH) && dec_q.fetch && (dec_q.kind != AK_CAS);
        src_wdata = old_q;
        r0_we     = (state == S_FINISH) && (dec_q.kind == AK_CAS);
        r0_wdata  = old_q;
    end

    // checks
    p_req_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> lock);
    p_read_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> (mem_req && !mem_we));
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && $past(lock)) |-> $stable(mem_addr));
    p_narrow_wdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_wide) |-> (mem_wdata[DATA_W-1:HALF_W] == '0));
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!busy && !mem_req && !done && !src_we && !r0_we));
    p_cas_no_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r0_we |-> !src_we);
    p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sim_atomic_rmw_unit.sv
`timescale 1ns/1ps
module sim_atomic_rmw_unit;
    localparam int DW = 64;
    localparam int AW = 32;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    opcode = '0;
    logic [7:0]    imm_op = '0;
    logic [AW-1:0] base_addr = '0;
    logic [OW-1:0] offset = '0;
    logic [DW-1:0] src_val = '0;
    logic [DW-1:0] r0_val = '0;
    logic          busy, done, error, lock, mem_req, mem_we, mem_wide;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ready = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          src_we, r0_we;
    logic [DW-1:0] src_wdata, r0_wdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    atomic_rmw_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm_op(imm_op),
        .base_addr(base_addr), .offset(offset), .src_val(src_val), .r0_val(r0_val),
        .busy(busy), .done(done), .error(error), .lock(lock),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .src_we(src_we), .src_wdata(src_wdata), .r0_we(r0_we), .r0_wdata(r0_wdata)
    );

    always #2 clk = ~clk;

    // behavioural memory
    logic [DW-1:0] mem_m [logic [AW-1:0]];
    int            latency = 0;
    int            lat_cnt = 0;
    bit            pend = 0;
    logic [AW-1:0] pend_addr = '0;
    int            n_req = 0;
    int            n_wr = 0;
    bit            saw_read = 0;
    logic [AW-1:0] last_addr = '0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mrd(input logic [AW-1:0] a);
        if (mem_m.exists(a)) return mem_m[a];
        return '0;
    endfunction

    always @(negedge clk) begin
        mem_ready = 1'b0;
        if (rst_n) begin
            if (mem_req || pend) chk(lock, "R4 lock during access", lock, 1);
            if (mem_req) begin
                chk(!pend, "R4 request while outstanding", pend, 0);
                n_req++;
                last_addr = mem_addr;
                pend_addr = mem_addr;
                lat_cnt = latency;
                pend = 1;
                if (mem_we) begin
                    chk(saw_read, "R4 write before read", saw_read, 1);
                    n_wr++;
                    if (mem_wide) mem_m[mem_addr] = mem_wdata;
                    else mem_m[mem_addr] = {mrd(mem_addr)[63:32], mem_wdata[31:0]};
                end else begin
                    saw_read = 1;
                end
            end else if (pend) begin
                if (lat_cnt == 0) begin
                    mem_ready = 1'b1;
                    mem_rdata = mrd(pend_addr);
                    pend = 0;
                end else begin
                    lat_cnt--;
                end
            end
        end
    end

    // reference model of one instruction
    task automatic ref_amo(input logic [7:0] code, input bit wide, input logic [DW-1:0] oldraw,
                           input logic [DW-1:0] s, input logic [DW-1:0] z,
                           output logic [DW-1:0] nmem, output bit wr,
                           output bit swe, output logic [DW-1:0] sv,
                           output bit rwe, output logic [DW-1:0] rv);
        logic [DW-1:0] m, o, sm, zm, n;
        m  = wide ? {DW{1'b1}} : 64'h0000_0000_FFFF_FFFF;
        o  = oldraw & m;
        sm = s & m;
        zm = z & m;
        wr = 1;
        case (code)
            8'h00, 8'h01: n = o + sm;
            8'h40, 8'h41: n = o | sm;
            8'h50, 8'h51: n = o & sm;
            8'hA0, 8'hA1: n = o ^ sm;
            8'hE1:        n = sm;
            default: begin n = sm; wr = (o == zm); end
        endcase
        n    = n & m;
        nmem = !wr ? oldraw : (wide ? n : {oldraw[63:32], n[31:0]});
        swe  = code[0] && (code != 8'hF1);
        sv   = o;
        rwe  = (code == 8'hF1);
        rv   = o;
    endtask

    task automatic run_amo(input string tag, input bit wide, input logic [7:0] code,
                           input logic [AW-1:0] b, input logic [OW-1:0] off,
                           input logic [DW-1:0] s, input logic [DW-1:0] z, input int lat);
        logic [AW-1:0] ea;
        logic [DW-1:0] nmem, sv, rv;
        bit wr, swe, rwe, got;
        int wr0;
        ea = b + {{(AW-OW){off[OW-1]}}, off};
        ref_amo(code, wide, mrd(ea), s, z, nmem, wr, swe, sv, rwe, rv);
        latency = lat;
        saw_read = 0;
        wr0 = n_wr;
        @(negedge clk);
        opcode = wide ? 8'hDB : 8'hC3;
        imm_op = code; base_addr = b; offset = off; src_val = s; r0_val = z;
        start = 1;
        @(negedge clk);
        start = 0;
        got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            if (done) got = 1;
            else @(negedge clk);
        end
        chk(got, {tag, " done seen"}, got, 1);
        chk(last_addr == ea, {tag, " R3 address"}, last_addr, ea);
        chk(src_we == swe, {tag, " R6 src_we"}, src_we, swe);
        if (swe) chk(src_wdata == sv, {tag, " R6 src value"}, src_wdata, sv);
        chk(r0_we == rwe, {tag, " R8 r0_we"}, r0_we, rwe);
        if (rwe) chk(r0_wdata == rv, {tag, " R8 r0 value"}, r0_wdata, rv);
        chk((n_wr - wr0) == (wr ? 1 : 0), {tag, " write count"}, n_wr - wr0, wr ? 1 : 0);
        chk(mrd(ea) == nmem, {tag, " memory result"}, mrd(ea), nmem);
        @(negedge clk);
        chk(!done && !busy, {tag, " R6 done single"}, done, 0);
    endtask

    task automatic run_bad(input string tag, input logic [7:0] opc, input logic [7:0] code);
        int r0c;
        r0c = n_req;
        @(negedge clk);
        opcode = opc; imm_op = code; start = 1;
        @(negedge clk);
        start = 0;
        chk(error == 1'b1, {tag, " R10 error pulse"}, error, 1);
        @(negedge clk);
        chk(error == 1'b0 && !busy, {tag, " R10 error one cycle"}, error, 0);
        for (int i = 0; i < 4; i++) begin
            chk(!done && !src_we && !r0_we, {tag, " R10 no writeback"}, done, 0);
            @(negedge clk);
        end
        chk(n_req == r0c, {tag, " R10 no memory request"}, n_req - r0c, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !lock && !mem_req && !done && !error && !src_we && !r0_we,
            "R11 reset idle", {busy, lock, mem_req, done, error}, 0);
        rst_n = 1;
        mem_m[32'h0000_1008] = 64'h0123_4567_89AB_CDEF;
        mem_m[32'h0000_2000] = 64'h0000_0000_FFFF_FFFF;
        mem_m[32'h0000_3000] = 64'hDEAD_BEEF_1234_5678;
        mem_m[32'h0000_0FF0] = 64'hF0F0_F0F0_F0F0_F0F0;
        mem_m[32'h0000_4000] = 64'hCAFE_0000_8000_0001;
        mem_m[32'h0000_5000] = 64'h1111_2222_3333_4444;
        mem_m[32'h0000_6000] = 64'h5555_6666_7777_8888;
        mem_m[32'h0000_7000] = 64'hAAAA_BBBB_CCCC_DDDD;
        repeat (2) @(negedge clk);
        // R1 R5 add 64 without fetch
        run_amo("R5 add64", 1, 8'h00, 32'h0000_1000, 16'h0008, 64'h1111_1111_1111_1111, 0, 0);
        // R5 R6 fetch add 64 with carry into upper half
        run_amo("R6 fadd64", 1, 8'h01, 32'h0000_2000, 16'h0000, 64'h1, 0, 1);
        // R9 fetch or 32 with garbage upper half
        run_amo("R9 for32", 0, 8'h41, 32'h0000_3000, 16'h0000, 64'hFFFF_0000_0F0F_0000, 0, 0);
        // R3 and 64 with negative offset
        run_amo("R3 and64", 1, 8'h50, 32'h0000_1000, 16'hFFF0, 64'hFF00_FF00_FF00_FF00, 0, 1);
        // R9 fetch xor 32 with longer latency
        run_amo("R9 fxor32", 0, 8'hA1, 32'h0000_4000, 16'h0000, 64'h1234_5678_8000_0001, 0, 3);
        // R2 or 64 nonfetch and xor 64 nonfetch
        run_amo("R2 or64", 1, 8'h40, 32'h0000_3000, 16'h0000, 64'h0000_0001_0000_0000, 0, 0);
        run_amo("R2 xor64", 1, 8'hA0, 32'h0000_2000, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
        // R7 exchange 64
        run_amo("R7 xchg64", 1, 8'hE1, 32'h0000_5000, 16'h0000, 64'h9999_8888_7777_6666, 0, 1);
        // R8 compare-exchange success and failure
        run_amo("R8 cas64 hit", 1, 8'hF1, 32'h0000_6000, 16'h0000, 64'h0BAD_F00D_0BAD_F00D,
                64'h5555_6666_7777_8888, 0);
        run_amo("R8 cas64 miss", 1, 8'hF1, 32'h0000_6000, 16'h0000, 64'h1, 64'h2, 3);
        // R9 compare-exchange 32 where r0 upper half differs
        run_amo("R9 cas32 hit", 0, 8'hF1, 32'h0000_7000, 16'h0000, 64'hFFFF_FFFF_0000_0042,
                64'h1234_5678_CCCC_DDDD, 1);
        // R10 illegal encodings; R1 illegal size and class; R2 exchange without fetch
        run_bad("R2 bad imm", 8'hDB, 8'h02);
        run_bad("R1 bad size", 8'hCB, 8'h00);
        run_bad("R2 xchg nofetch", 8'hC3, 8'hE0);
        run_bad("R1 bad class", 8'hDA, 8'h01);
        // sequencer still usable after errors
        run_amo("R5 and32", 0, 8'h51, 32'h0000_5000, 16'h0000, 64'h0, 0, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule